// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level page table from memory. A request carries the linear address together with two access attributes: whether the access is a write and whether it comes from user level. The walker takes the frame number of the top-level table from a base input. It reads the top-level entry and then the second-level entry through a single 32-bit word port, and it checks the entry flags at each level.

If both levels allow the access, the walker writes the accessed flag back into both entries. On a write it also sets the modified flag in the second-level entry. Each update is a read-modify-write, and an entry whose flags already hold the required values is not written. The walker then returns the physical address. Any failed check ends the walk with a page fault (exception vector 14). The fault report carries the linear address and a three-bit cause code. Only one request is in flight at a time, and nothing is cached between walks.

Top module: `pt_walker`

## Requirements
- R1: The linear address is split as top-level index in bits 31:22, second-level index in bits 21:12 and page offset in bits 11:0. On success the physical address is the second-level entry's frame field (bits 31:12) followed by the 12-bit offset.
- R2: An entry is read from frame base × 4096 + index × 4. For the top-level entry the frame base is the `dir_base_frame` input. For the second-level entry it is bits 31:12 of the top-level entry. Every memory access is word aligned and holds its address until acknowledged.
- R3: An entry whose present flag (bit 0) is clear, at either level, ends the walk with a fault. Bit 0 of the cause code is then 0.
- R4: A write access where either level's entry has the writable flag (bit 1) clear faults, with cause bit 0 = 1.
- R5: A user access where either level's entry has the user flag (bit 2) clear faults, with cause bit 0 = 1.
- R6: On success the accessed flag (bit 5) is set in both entries in memory.
- R7: On a successful write access the modified flag (bit 6) is set in the second-level entry. A read access leaves bit 6 as it was.
- R8: An entry is written only if its flags change. The number of memory writes per walk is exactly the number of entries that needed a change.
- R9: The cause code is {user, write, protection} in bits 2:0. `resp_laddr` returns the request's linear address on both success and fault.
- R10: `req_ready` is high only when the walker is idle. It drops in the cycle after a request is accepted and stays low until the response.
- R11: After reset the walker is idle with `req_ready` high and `resp_valid` and `mem_req` low. `resp_valid` is a one-cycle pulse.
- R12: A faulting walk performs no memory write and leaves both entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_base_frame | input | 20 | Frame number of the top-level table |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user level |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_fault | output | 1 | Response is a page fault |
| resp_paddr | output | 32 | Physical address on success |
| resp_laddr | output | 32 | Linear address of the answered request |
| resp_fcode | output | 3 | Fault cause {user, write, protection} |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Updated entry on writes |
| mem_ack | input | 1 | Memory completes the access |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The hardest case to reach is a walk where both levels are present and one level denies the access. This has to be separated from a walk that succeeds but finds some accessed or modified flags already set, because the number of write-back cycles then varies from zero to two. The bench reaches every such case with a sweep. It covers all eight flag combinations at each level, both access types, both privilege levels and four preset patterns of the accessed and modified flags. It also moves the table bases and the address fields between walks. For each walk it compares the response, the write count and the final memory words with values it derives from the flag arithmetic.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned FLG_PRESENT  = 0;
  localparam int unsigned FLG_WRITABLE = 1;
  localparam int unsigned FLG_USER     = 2;
  localparam int unsigned FLG_ACCESSED = 5;
  localparam int unsigned FLG_MODIFIED = 6;

  typedef enum logic [3:0] {
    WS_IDLE,
    WS_RD_TOP,
    WS_CHK_TOP,
    WS_RD_LEAF,
    WS_CHK_LEAF,
    WS_UPD_TOP,
    WS_UPD_LEAF,
    WS_DONE,
    WS_FAULT
  } walk_state_e;

  typedef struct packed {
    logic user;
    logic write;
    logic prot;
  } fault_code_t;
endpackage

// File: rtl/pw_perm_check.sv
module pw_perm_check (
  input  logic flag_present_i,
  input  logic flag_writable_i,
  input  logic flag_user_i,
  input  logic acc_write_i,
  input  logic acc_user_i,
  output logic not_present_o,
  output logic prot_viol_o
);
  always_comb begin
    not_present_o = ~flag_present_i;
    prot_viol_o   = (acc_write_i & ~flag_writable_i) | (acc_user_i & ~flag_user_i);
  end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned DIR_W = 10,
  parameter int unsigned TBL_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic [LA_W-OFF_W-1:0] base_frame_i,
  input  logic [LA_W-OFF_W-1:0] top_frame_i,
  input  logic [DIR_W-1:0]      top_idx_i,
  input  logic [TBL_W-1:0]      leaf_idx_i,
  input  logic                  sel_leaf_i,
  output logic [LA_W-1:0]       addr_o
);
  localparam int unsigned IDX_W = OFF_W - 2;

  logic [LA_W-OFF_W-1:0] frame;
  logic [IDX_W-1:0]      idx;

  always_comb begin
    if (sel_leaf_i) begin
      frame = top_frame_i;
      idx   = IDX_W'(leaf_idx_i);
    end else begin
      frame = base_frame_i;
      idx   = IDX_W'(top_idx_i);
    end
    addr_o = {frame, idx, 2'b00};
  end
endmodule

// File: rtl/pw_entry_update.sv
module pw_entry_update
  import pw_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] entry_i,
  input  logic         set_modified_i,
  output logic [W-1:0] entry_o,
  output logic         need_wr_o
);
  always_comb begin
    entry_o = entry_i;
    entry_o[FLG_ACCESSED] = 1'b1;
    if (set_modified_i) entry_o[FLG_MODIFIED] = 1'b1;
    need_wr_o = (entry_o != entry_i);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int unsigned LA_W  = 32,
  parameter int unsigned DIR_W = 10,
  parameter int unsigned TBL_W = 10,
  parameter int unsigned OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LA_W-OFF_W-1:0] dir_base_frame,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LA_W-1:0]       req_laddr,
  input  logic                  req_write,
  input  logic                  req_user,
  output logic                  resp_valid,
  output logic                  resp_fault,
  output logic [LA_W-1:0]       resp_paddr,
  output logic [LA_W-1:0]       resp_laddr,
  output logic [2:0]            resp_fcode,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [LA_W-1:0]       mem_addr,
  output logic [LA_W-1:0]       mem_wdata,
  input  logic                  mem_ack,
  input  logic [LA_W-1:0]       mem_rdata
);
  localparam int unsigned FRM_W = LA_W - OFF_W;

  walk_state_e state_q, state_d;
  logic [LA_W-1:0] laddr_q;
  logic            wr_q, usr_q;
  logic [LA_W-1:0] top_q, leaf_q;
  fault_code_t     fcode_q, fcode_d;

  logic accept, top_ld, leaf_ld, fcode_ld;
  logic top_np, top_prot, leaf_np, leaf_prot;
  logic [LA_W-1:0] top_new, leaf_new;
  logic top_need, leaf_need;
  logic sel_leaf;

  pw_perm_check i_top_chk (
    .flag_present_i (top_q[FLG_PRESENT]),
    .flag_writable_i(top_q[FLG_WRITABLE]),
    .flag_user_i    (top_q[FLG_USER]),
    .acc_write_i    (wr_q),
    .acc_user_i     (usr_q),
    .not_present_o  (top_np),
    .prot_viol_o    (top_prot)
  );

  pw_perm_check i_leaf_chk (
    .flag_present_i (leaf_q[FLG_PRESENT]),
    .flag_writable_i(leaf_q[FLG_WRITABLE]),
    .flag_user_i    (leaf_q[FLG_USER]),
    .acc_write_i    (wr_q),
    .acc_user_i     (usr_q),
    .not_present_o  (leaf_np),
    .prot_viol_o    (leaf_prot)
  );

  pw_entry_update #(.W(LA_W)) i_top_upd (
    .entry_i       (top_q),
    .set_modified_i(1'b0),
    .entry_o       (top_new),
    .need_wr_o     (top_need)
  );

  pw_entry_update #(.W(LA_W)) i_leaf_upd (
    .entry_i       (leaf_q),
    .set_modified_i(wr_q),
    .entry_o       (leaf_new),
    .need_wr_o     (leaf_need)
  );

  assign sel_leaf = (state_q == WS_RD_LEAF) || (state_q == WS_UPD_LEAF);

  pw_addr_gen #(.LA_W(LA_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)) i_addr (
    .base_frame_i(dir_base_frame),
    .top_frame_i (top_q[LA_W-1:OFF_W]),
    .top_idx_i   (laddr_q[LA_W-1 -: DIR_W]),
    .leaf_idx_i  (laddr_q[OFF_W +: TBL_W]),
    .sel_leaf_i  (sel_leaf),
    .addr_o      (mem_addr)
  );

  // next-state and control
  always_comb begin
    state_d  = state_q;
    fcode_d  = fcode_q;
    fcode_ld = 1'b0;
    accept   = 1'b0;
    top_ld   = 1'b0;
    leaf_ld  = 1'b0;
    case (state_q)
      WS_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = WS_RD_TOP;
        end
      end
      WS_RD_TOP: begin
        if (mem_ack) begin
          top_ld  = 1'b1;
          state_d = WS_CHK_TOP;
        end
      end
      WS_CHK_TOP: begin
        if (top_np || top_prot) begin
          fcode_ld = 1'b1;
          fcode_d  = '{user: usr_q, write: wr_q, prot: ~top_np};
          state_d  = WS_FAULT;
        end else begin
          state_d = WS_RD_LEAF;
        end
      end
      WS_RD_LEAF: begin
        if (mem_ack) begin
          leaf_ld = 1'b1;
          state_d = WS_CHK_LEAF;
        end
      end
      WS_CHK_LEAF: begin
        if (leaf_np || leaf_prot) begin
          fcode_ld = 1'b1;
          fcode_d  = '{user: usr_q, write: wr_q, prot: ~leaf_np};
          state_d  = WS_FAULT;
        end else if (top_need) begin
          state_d = WS_UPD_TOP;
        end else if (leaf_need) begin
          state_d = WS_UPD_LEAF;
        end else begin
          state_d = WS_DONE;
        end
      end
      WS_UPD_TOP: begin
        if (mem_ack) state_d = leaf_need ? WS_UPD_LEAF : WS_DONE;
      end
      WS_UPD_LEAF: begin
        if (mem_ack) state_d = WS_DONE;
      end
      WS_DONE:  state_d = WS_IDLE;
      WS_FAULT: state_d = WS_IDLE;
      default:  state_d = WS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      laddr_q <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      top_q   <= '0;
      leaf_q  <= '0;
      fcode_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        laddr_q <= req_laddr;
        wr_q    <= req_write;
        usr_q   <= req_user;
      end
      if (top_ld)   top_q   <= mem_rdata;
      if (leaf_ld)  leaf_q  <= mem_rdata;
      if (fcode_ld) fcode_q <= fcode_d;
    end
  end

  // outputs
  always_comb begin
    req_ready  = (state_q == WS_IDLE);
    mem_req    = (state_q == WS_RD_TOP) || (state_q == WS_RD_LEAF) ||
                 (state_q == WS_UPD_TOP) || (state_q == WS_UPD_LEAF);
    mem_we     = (state_q == WS_UPD_TOP) || (state_q == WS_UPD_LEAF);
    mem_wdata  = (state_q == WS_UPD_LEAF) ? leaf_new : top_new;
    resp_valid = (state_q == WS_DONE) || (state_q == WS_FAULT);
    resp_fault = (state_q == WS_FAULT);
    resp_paddr = {leaf_q[LA_W-1:OFF_W], laddr_q[OFF_W-1:0]};
    resp_laddr = laddr_q;
    resp_fcode = fcode_q;
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned LA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_fault,
  input logic [LA_W-1:0] resp_paddr,
  input logic [LA_W-1:0] resp_laddr,
  input logic            mem_req,
  input logic            mem_we,
  input logic [LA_W-1:0] mem_addr,
  input logic [LA_W-1:0] mem_wdata,
  input logic            mem_ack
);
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_hold_until_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_wb_sets_accessed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]);

  assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_offset_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_paddr[11:0] == resp_laddr[11:0]));

  assert_no_mem_while_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
endmodule

bind pt_walker pt_walker_chk #(.LA_W(LA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .resp_valid(resp_valid),
  .resp_fault(resp_fault),
  .resp_paddr(resp_paddr),
  .resp_laddr(resp_laddr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] dir_base_frame;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_laddr;
  logic        resp_valid, resp_fault;
  logic [31:0] resp_paddr, resp_laddr;
  logic [2:0]  resp_fcode;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int total = 0;
  int bad   = 0;
  int wr_cnt = 0;
  logic [31:0] mem [0:4095];

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .dir_base_frame(dir_base_frame),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .req_write(req_write), .req_user(req_user),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .resp_laddr(resp_laddr), .resp_fcode(resp_fcode),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic int midx(input logic [31:0] a);
    return int'({a[13:12], a[11:2]});
  endfunction

  // memory model: one-cycle response, acts on the falling edge
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[midx(mem_addr)];
      if (mem_we) begin
        mem[midx(mem_addr)] <= mem_wdata;
        wr_cnt = wr_cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic walk(input int n, input logic [2:0] tf, input logic [2:0] lf,
                      input logic [1:0] ad, input bit wr, input bit usr);
    logic [19:0] base, tframe, pfn;
    logic [9:0]  di, ti;
    logic [11:0] off;
    logic [31:0] la, top0, leaf0, top_exp, leaf_exp;
    int tix, lix, waitc, exp_wr;
    bit exp_fault;
    logic [2:0] exp_code;
    base   = (n % 2 == 0) ? 20'd0 : 20'd3;
    tframe = ((n / 2) % 2 == 0) ? 20'd1 : 20'd2;
    di  = 10'((n * 37 + 3) % 1024);
    ti  = 10'((n * 91 + 5) % 1024);
    off = 12'((n * 123 + 7) % 4096);
    pfn = 20'hA5000 ^ 20'(n * 13);
    la  = {di, ti, off};
    top0  = {tframe, 12'h000} | {25'd0, 1'b0, ad[0], 2'b00, tf};
    leaf0 = {pfn, 12'h000} | {25'd0, ad[1], ad[1], 2'b00, lf};
    tix = int'({base[1:0], di});
    lix = int'({tframe[1:0], ti});
    mem[tix] = top0;
    mem[lix] = leaf0;

    exp_fault = 1'b1;
    exp_code  = {usr, wr, 1'b0};
    if (!tf[0]) exp_code[0] = 1'b0;
    else if ((usr && !tf[2]) || (wr && !tf[1])) exp_code[0] = 1'b1;
    else if (!lf[0]) exp_code[0] = 1'b0;
    else if ((usr && !lf[2]) || (wr && !lf[1])) exp_code[0] = 1'b1;
    else exp_fault = 1'b0;

    if (exp_fault) begin
      top_exp  = top0;
      leaf_exp = leaf0;
      exp_wr   = 0;
    end else begin
      top_exp  = top0 | 32'h20;
      leaf_exp = leaf0 | 32'h20 | (wr ? 32'h40 : 32'h0);
      exp_wr   = ((top_exp != top0) ? 1 : 0) + ((leaf_exp != leaf0) ? 1 : 0);
    end

    dir_base_frame = base;
    @(negedge clk);
    wr_cnt    = 0;
    req_valid = 1'b1;
    req_laddr = la;
    req_write = wr;
    req_user  = usr;
    @(negedge clk);
    req_valid = 1'b0;
    req_laddr = 32'hDEAD_BEEF;
    if (n < 4) check(req_ready == 1'b0, "R10", $sformatf("ready after accept act=%b exp=0", req_ready));
    waitc = 0;
    while (!resp_valid && waitc < 50) begin
      @(negedge clk);
      waitc++;
    end
    check(resp_valid == 1'b1 && resp_fault == exp_fault, exp_fault ? "R3" : "R1",
          $sformatf("n=%0d fault act=%b exp=%b", n, resp_fault, exp_fault));
    if (exp_fault) begin
      check(resp_fcode == exp_code, exp_code[0] ? (wr ? "R4" : "R5") : "R3",
            $sformatf("n=%0d code act=%b exp=%b", n, resp_fcode, exp_code));
    end else begin
      check(resp_paddr == {pfn, off}, "R1",
            $sformatf("n=%0d pa act=%h exp=%h", n, resp_paddr, {pfn, off}));
    end
    check(resp_laddr == la, "R9", $sformatf("n=%0d laddr act=%h exp=%h", n, resp_laddr, la));
    @(negedge clk);
    check(resp_valid == 1'b0 && req_ready == 1'b1, "R11",
          $sformatf("pulse act=%b%b exp=01", resp_valid, req_ready));
    check(wr_cnt == exp_wr, exp_fault ? "R12" : "R8",
          $sformatf("n=%0d writes act=%0d exp=%0d", n, wr_cnt, exp_wr));
    check(mem[tix] == top_exp, exp_fault ? "R12" : "R6",
          $sformatf("n=%0d top act=%h exp=%h", n, mem[tix], top_exp));
    check(mem[lix] == leaf_exp, exp_fault ? "R12" : "R7",
          $sformatf("n=%0d leaf act=%h exp=%h", n, mem[lix], leaf_exp));
  endtask

  initial begin
    int n;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_laddr = '0;
    req_write = 1'b0;
    req_user  = 1'b0;
    dir_base_frame = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && resp_valid == 1'b0 && mem_req == 1'b0, "R11",
          $sformatf("reset act=%b%b%b exp=100", req_ready, resp_valid, mem_req));
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && mem_req == 1'b0, "R11",
          $sformatf("after release act=%b%b exp=10", req_ready, mem_req));
    n = 0;
    // sweep: R2 via moving bases, R4/R5 via flag patterns
    for (int tf = 0; tf < 8; tf++)
      for (int lf = 0; lf < 8; lf++)
        for (int ad = 0; ad < 4; ad++)
          for (int acc = 0; acc < 4; acc++) begin
            walk(n, 3'(tf), 3'(lf), 2'(ad), acc[0], acc[1]);
            n++;
          end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule